// File: doc/BRIEF.md
# Four-Channel Voltage-Qualified Rail Gate Controller

This block drives the enables of four external power-rail switches. During normal operation each channel works alone. A channel's gate enable turns on one clock after that channel's undervoltage comparator reports its rail as good while the shared active-low enable is asserted. No channel waits for any other channel. A common power-good output rises only when every gate reports fully on and that condition has held for a programmable number of cycles. If one rail later sags, only that channel's gate drops, and power-good drops with it.

Deasserting the enable starts a forced drain. Power-good is pulled low and stays latched low for the whole drain. Each channel then waits its own programmed number of cycles before its gate is cleared, so the delays set the order in which the rails turn off. The drain ends only when every gate enable is off and every gate reports below its low threshold. After that, the channels again follow their comparators. A synchronous kill input clears everything at once. The analog switches and comparators sit outside the block and reach it only as status flags.

Top module: `rail_gate_ctrl`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, all four gate_en_o bits and pgood_o are 0.
- R2: Outside a drain, with en_n_i low and kill_i low, gate_en_o[i] equals the uv_ok_i[i] sampled at the previous clock edge, for each channel independently of the others.
- R3: A uv_ok_i[i] of 0 at a clock edge clears gate_en_o[i] and pgood_o at that edge, and leaves the other channels' enables unchanged.
- R4: pgood_o rises at the HOLD-th consecutive edge at which en_n_i is low, all uv_ok_i bits are 1, all gate_en_o bits are 1 and all gate_full_i bits are 1. HOLD defaults to 20, and the bench uses 20.
- R5: If any gate_full_i bit is 0 at an edge before pgood_o rises, the hold count restarts from zero at that edge.
- R6: Sampling en_n_i high at an edge, after it was low at the previous edge, starts a drain. At that edge pgood_o goes low. Channel i's enable clears exactly OFF_DLY[i] edges later, so a delay of 0 clears it at the same edge. The default delays are 12, 8, 4 and 0 cycles for channels 0, 1, 2 and 3, so channel 3 turns off first and channel 0 last.
- R7: During a drain no gate enable turns on and pgood_o stays low, even if en_n_i returns low. The drain ends at the first edge at which every delay has expired, every gate enable is 0 and all gate_low_i bits are 1. Gates follow uv_ok_i again from the following edge.
- R8: kill_i high at an edge clears all gate enables and pgood_o at that edge and aborts any drain. Gates follow uv_ok_i again from the first edge after kill_i falls.
- R9: While en_n_i is high, no gate enable goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| kill_i | input | 1 | Synchronous active-high clear of all gates and power-good |
| en_n_i | input | 1 | Active-low run enable |
| uv_ok_i | input | 4 | Per-channel rail-above-undervoltage-threshold flags |
| gate_full_i | input | 4 | Per-channel gate-fully-on status |
| gate_low_i | input | 4 | Per-channel gate-below-low-threshold status |
| gate_en_o | output | 4 | Per-channel gate enable |
| pgood_o | output | 1 | Common power-good / reset release |

## Verification
The assertions take the status inputs to be plain synchronous levels that settle before each clock edge. They make no assumption that gate_full_i or gate_low_i agree with gate_en_o. Each rule is stated from the enables, the uv flags and the drain state alone. The stimulus changes inputs only just after an edge. It models the status flags by hand: full is raised only after the gates are on, and low is raised only after the drain has cleared every enable. This means every drain, hold and restart window is reached through legal sequences.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_DRAIN = 1'b1
  } rgc_mode_e;
endpackage

// File: rtl/rgc_chan.sv
module rgc_chan #(
  parameter int             DW  = 8,
  parameter logic [DW-1:0]  DLY = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic start_off_i,
  input  logic drain_i,
  input  logic run_en_i,
  input  logic uv_ok_i,
  output logic gate_o,
  output logic idle_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic          gate_q, gate_d;
  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (kill_i) begin
      gate_d = 1'b0;
      cnt_d  = '0;
    end else if (start_off_i) begin
      cnt_d  = DLY;
      gate_d = (DLY != '0) & gate_q & uv_ok_i;
    end else if (drain_i) begin
      if (cnt_q != '0) begin
        cnt_d  = cnt_q - ONE;
        gate_d = gate_q & uv_ok_i & (cnt_q != ONE);
      end else begin
        gate_d = 1'b0;
      end
    end else begin
      gate_d = uv_ok_i & run_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_o = gate_q;
  assign idle_o = (cnt_q == '0);

  // R3: a sagging rail never leaves its gate on past the edge
  a_r3_uv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok_i |=> !gate_o);

  // R6: the last counted cycle of a drain delay turns the gate off
  a_r6_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_i && !start_off_i && !kill_i && cnt_q == ONE) |=> !gate_o);

  generate
    if (DLY == '0) begin : g_zero
      // R6: zero delay turns off at the start edge itself
      a_r6_zero_dly: assert property (@(posedge clk) disable iff (!rst_n)
        start_off_i |=> !gate_o);
    end
  endgenerate
endmodule

// File: rtl/rgc_seq.sv
module rgc_seq
  import rgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic en_n_i,
  input  logic quiet_i,
  output logic drain_o,
  output logic start_off_o,
  output logic run_en_o
);
  rgc_mode_e mode_q, mode_d;
  logic      en_prev_q, en_prev_d;

  assign start_off_o = (mode_q == MODE_RUN) & en_prev_q & en_n_i & ~kill_i;
  assign run_en_o    = (mode_q == MODE_RUN) & ~en_n_i;
  assign drain_o     = (mode_q == MODE_DRAIN);

  always_comb begin
    mode_d    = mode_q;
    en_prev_d = ~en_n_i;
    if (kill_i) begin
      mode_d = MODE_RUN;
    end else begin
      unique case (mode_q)
        MODE_RUN:   if (start_off_o) mode_d = MODE_DRAIN;
        MODE_DRAIN: if (quiet_i)     mode_d = MODE_RUN;
        default:    mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RUN;
      en_prev_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      en_prev_q <= en_prev_d;
    end
  end

  // R7: a drain is only left through completion or kill
  a_r7_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_o && !quiet_i && !kill_i) |=> drain_o);
endmodule

// File: rtl/rgc_hold.sv
module rgc_hold #(
  parameter int HOLD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic qual_i,
  output logic pgood_o
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          pg_q, pg_d;

  always_comb begin
    cnt_d = cnt_q;
    pg_d  = pg_q;
    if (kill_i || !qual_i) begin
      cnt_d = '0;
      pg_d  = 1'b0;
    end else if (cnt_q == LAST) begin
      pg_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pg_q  <= pg_d;
    end
  end

  assign pgood_o = pg_q;

  // R5: a broken qualification drops power-good and the count
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_i |=> (!pgood_o && cnt_q == '0));
endmodule

// File: rtl/rail_gate_ctrl.sv
module rail_gate_ctrl #(
  parameter int                   NCH     = 4,
  parameter int                   DW      = 8,
  parameter int                   HOLD    = 20,
  parameter logic [NCH-1:0][DW-1:0] OFF_DLY = {8'd0, 8'd4, 8'd8, 8'd12}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           kill_i,
  input  logic           en_n_i,
  input  logic [NCH-1:0] uv_ok_i,
  input  logic [NCH-1:0] gate_full_i,
  input  logic [NCH-1:0] gate_low_i,
  output logic [NCH-1:0] gate_en_o,
  output logic           pgood_o
);
  logic           drain, start_off, run_en, quiet, qual;
  logic [NCH-1:0] idle;

  assign quiet = (&idle) & ~(|gate_en_o) & (&gate_low_i);
  assign qual  = run_en & (&uv_ok_i) & (&gate_en_o) & (&gate_full_i);

  rgc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .kill_i      (kill_i),
    .en_n_i      (en_n_i),
    .quiet_i     (quiet),
    .drain_o     (drain),
    .start_off_o (start_off),
    .run_en_o    (run_en)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      rgc_chan #(.DW(DW), .DLY(OFF_DLY[g])) u_ch (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill_i      (kill_i),
        .start_off_i (start_off),
        .drain_i     (drain),
        .run_en_i    (run_en),
        .uv_ok_i     (uv_ok_i[g]),
        .gate_o      (gate_en_o[g]),
        .idle_o      (idle[g])
      );
    end
  endgenerate

  rgc_hold #(.HOLD(HOLD)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill_i  (kill_i),
    .qual_i  (qual),
    .pgood_o (pgood_o)
  );

  // R8: kill clears every output at the edge
  a_r8_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (gate_en_o == '0 && !pgood_o));

  // R6: enable removal drops power-good at the edge
  a_r6_pgood_drop: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |=> !pgood_o);

  // R9: no gate turns on while enable is inactive
  a_r9_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |=> ((gate_en_o & ~$past(gate_en_o)) == '0));

  // R7: no turn-on and no power-good while draining
  a_r7_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    drain |=> ((gate_en_o & ~$past(gate_en_o)) == '0));
  a_r7_pg_low: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> !pgood_o);

  // R4: power-good rises only after full gates were seen
  a_r4_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> $past(&gate_full_i));
endmodule

// File: tb/tb_rail_gate_ctrl.sv
module tb_rail_gate_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HOLD = 20;
  localparam int DL0 = 12, DL1 = 8, DL2 = 4, DL3 = 0;

  logic       clk, rst_n, kill, en_n;
  logic [3:0] uv, full, low, gate;
  logic       pg;
  int         n_cmp, n_bad;

  rail_gate_ctrl #(.NCH(4), .DW(8), .HOLD(HOLD),
                   .OFF_DLY({8'(DL3), 8'(DL2), 8'(DL1), 8'(DL0)})) dut (
    .clk(clk), .rst_n(rst_n), .kill_i(kill), .en_n_i(en_n),
    .uv_ok_i(uv), .gate_full_i(full), .gate_low_i(low),
    .gate_en_o(gate), .pgood_o(pg));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {en_n, uv[3:0], expected gate[3:0]}, pgood expected 0 (R2, R3)
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 4'b0001, 4'b0001},
    {1'b0, 4'b0101, 4'b0101},
    {1'b0, 4'b1111, 4'b1111},
    {1'b0, 4'b1011, 4'b1011},
    {1'b0, 4'b1111, 4'b1111},
    {1'b0, 4'b0000, 4'b0000},
    {1'b0, 4'b0110, 4'b0110},
    {1'b0, 4'b1111, 4'b1111}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual gate/pg=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] drain_exp(int k);
    return {DL3 > k, DL2 > k, DL1 > k, DL0 > k};
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; kill = 1'b0; en_n = 1'b1;
    uv = 4'b1111; full = 4'b0000; low = 4'b1111;
    step(3);
    chk("R1 in reset", {gate, pg}, 5'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release", {gate, pg}, 5'b0);
    chk("R9 enable off", {gate, pg}, 5'b0);
    uv = 4'b0000; low = 4'b0000;
    step(1);

    for (int v = 0; v < 8; v++) begin
      en_n = VEC[v][8];
      uv   = VEC[v][7:4];
      step(1);
      chk($sformatf("R2/R3 vector %0d", v), {gate, pg}, {VEC[v][3:0], 1'b0});
    end

    // R4: hold window
    full = 4'b1111;
    step(HOLD - 1);
    chk("R4 before hold", {gate, pg}, 5'b11110);
    step(1);
    chk("R4 at hold", {gate, pg}, 5'b11111);

    // R3: sag drops one gate and power-good
    uv = 4'b1101;
    step(1);
    chk("R3 sag", {gate, pg}, 5'b11010);
    uv = 4'b1111;
    step(1);
    chk("R3 recover", {gate, pg}, 5'b11110);

    // R5: restart on full loss before release
    step(10);
    full = 4'b1011;
    step(1);
    chk("R5 full lost", {gate, pg}, 5'b11110);
    full = 4'b1111;
    step(HOLD - 1);
    chk("R5 restarted not yet", {gate, pg}, 5'b11110);
    step(1);
    chk("R5 restarted release", {gate, pg}, 5'b11111);

    // R6 / R7: drain
    en_n = 1'b1;
    full = 4'b0000;
    step(1);
    chk("R6 k=0", {gate, pg}, {drain_exp(0), 1'b0});
    for (int k = 1; k <= 13; k++) begin
      if (k == 5) en_n = 1'b0;
      step(1);
      chk($sformatf("R6/R7 drain k=%0d", k), {gate, pg}, {drain_exp(k), 1'b0});
    end
    step(3);
    chk("R7 waits for low", {gate, pg}, 5'b0);
    low = 4'b1111;
    step(1);
    chk("R7 completion edge", {gate, pg}, 5'b0);
    step(1);
    chk("R7 resume", {gate, pg}, 5'b11110);
    low = 4'b0000;

    // R8: kill
    full = 4'b1111;
    step(5);
    kill = 1'b1;
    step(1);
    chk("R8 kill", {gate, pg}, 5'b0);
    step(1);
    chk("R8 kill held", {gate, pg}, 5'b0);
    kill = 1'b0;
    step(1);
    chk("R8 release", {gate, pg}, 5'b11110);

    // R9: enable off with rails good
    en_n = 1'b1;
    step(1);
    chk("R9 drain start", {gate, pg}, {drain_exp(0), 1'b0});
    kill = 1'b1;
    step(1);
    kill = 1'b0;
    step(3);
    chk("R9 stays off", {gate, pg}, 5'b0);

    finish_run();
  end
endmodule